// File: doc/BRIEF.md
# Streaming Set-Tagged Reduction Scheduler

This block sums a stream of tagged values into one total per tag (a "set", such as a matrix row). It has only one pipelined adder. That adder takes a fresh pair of operands every cycle and returns the sum `LAT` cycles later. Because partial sums of several sets travel through the adder at the same time, the block does not wait for each set to finish. Instead, every cycle it picks the two adder operands by comparing set tags. The candidates are the arriving value, a small pool of held partial sums, and the value leaving the adder.

The arithmetic is a wrapping integer add of `DATA_W` bits. Internally the block tracks, for each set, how many partial values are still alive and whether the set's final input has arrived. When the last surviving value of a finished set leaves the adder, it is presented on the output for one cycle.

Users must follow three rules:
- An input must stay steady while `inReady` is low.
- A set tag must not be reused until its total has been emitted.
- No more than four sets may have inputs outstanding at once (buffer pool size minus two).

Top module: `set_reduce`

## Requirements
- R1: When the value leaving the adder is still live (not emitted) and a held value carries the same set, those two are the adder operands. This choice has the highest priority.
- R2: Otherwise, if two held values share a set, they are added together.
- R3: Otherwise, if an accepted input has the same set as the live adder output, the input and the adder output are added.
- R4: Otherwise, if an accepted input matches a held value's set, the input and that held value are added.
- R5: Otherwise, an accepted input enters the adder paired with zero. A live adder output that no rule consumed is held in a free buffer. If no input is accepted and no buffer is free, that output is fed back into the adder paired with zero.
- R6: Each set's total appears exactly once, with `outValid` high for one cycle, `outSet` naming the set, and `outSum` equal to the wrapping sum of all its inputs. This holds for any interleaving of sets.
- R7: A value issued to the adder in cycle C reaches the adder output in cycle C+LAT. On an idle block, a single-value set accepted in cycle C therefore appears on `outValid` in cycle C+LAT, and not before.
- R8: After reset, `outValid` is low and `inReady` is high. `inReady` is high exactly when at least two buffers are free. An input offered while `inReady` is low is not taken.
- R9: In a cycle with no live adder output, no accepted input and no matching pair, a held value whose set is complete is issued paired with zero, so that it can reach the output.
- R10: Once a set's total has been emitted, its tag starts from zero when reused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An input value is offered |
| inReady | output | 1 | An offered input is accepted this cycle |
| inSet | input | SET_W | Set tag of the input |
| inData | input | DATA_W | Input value |
| inLast | input | 1 | This input is the final one of its set |
| outValid | output | 1 | A set total is presented |
| outSet | output | SET_W | Set tag of the total |
| outSum | output | DATA_W | Total of the set |

## Verification
The bench targets the following cases:

- **Single-value set on an idle block.** Its timing pins down the adder depth. A design with an off-by-one pipeline would emit it a cycle early or late.
- **Long run of one set, one value per cycle.** This forces the input to combine with the adder output. A design that dropped or double-counted the recirculating value would produce a wrong total.
- **Held value meets a matching adder output while another single-value set arrives.** This is arranged so the arriving value is parked. A design lacking the idle reissue would never emit that parked total, and the queue would not drain.
- **Dense interleaving of sets and reuse of tags after emission.** A design that confused sets, or kept stale counts across reuse, would show wrong or missing totals.

// File: rtl/set_reduce_pkg.sv
package set_reduce_pkg;

  // size of the partial-sum pool shared by the whole block
  parameter int NBUF  = 6;
  parameter int IDX_W = $clog2(NBUF);

  typedef enum logic [1:0] {A_IN, A_AO, A_BUF} srcA_e;
  typedef enum logic [1:0] {B_ZERO, B_AO, B_BUF} srcB_e;

  // strobes from the scheduler to the datapath
  typedef struct packed {
    logic             issue;
    srcA_e            srcA;
    srcB_e            srcB;
    logic [IDX_W-1:0] idxA;
    logic [IDX_W-1:0] idxB;
    logic [NBUF-1:0]  freeMask;
    logic             wrIn;
    logic             wrAo;
  } strobe_t;

endpackage

// File: rtl/set_reduce_dp.sv
module set_reduce_dp
  import set_reduce_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SET_W  = 3,
  parameter int LAT    = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [SET_W-1:0]  inSet,
  input  logic [DATA_W-1:0] inData,
  output logic [NBUF-1:0]   bufValid,
  output logic [SET_W-1:0]  bufSet [NBUF],
  output logic              aoValid,
  output logic [SET_W-1:0]  aoSet,
  output logic [DATA_W-1:0] aoData
);

  logic [DATA_W-1:0] bufData [NBUF];
  logic              pipeV [LAT];
  logic [SET_W-1:0]  pipeS [LAT];
  logic [DATA_W-1:0] pipeD [LAT];

  logic [DATA_W-1:0] opA, opB;
  logic [SET_W-1:0]  issueSet;
  logic [IDX_W-1:0]  slot0, slot1;
  logic              got0, got1;
  logic [NBUF-1:0]   avail;

  assign aoValid = pipeV[LAT-1];
  assign aoSet   = pipeS[LAT-1];
  assign aoData  = pipeD[LAT-1];

  // operand selection
  always_comb begin
    unique case (st.srcA)
      A_AO:    begin opA = aoData;           issueSet = aoSet;           end
      A_BUF:   begin opA = bufData[st.idxA]; issueSet = bufSet[st.idxA]; end
      default: begin opA = inData;           issueSet = inSet;           end
    endcase
    unique case (st.srcB)
      B_AO:    opB = aoData;
      B_BUF:   opB = bufData[st.idxB];
      default: opB = '0;
    endcase
  end

  // first two slots free once this cycle's consumed entries are released
  always_comb begin
    avail = ~bufValid | st.freeMask;
    slot0 = '0; slot1 = '0; got0 = 1'b0; got1 = 1'b0;
    for (int i = 0; i < NBUF; i++) begin
      if (avail[i] && !got0) begin
        slot0 = IDX_W'(i); got0 = 1'b1;
      end else if (avail[i] && !got1) begin
        slot1 = IDX_W'(i); got1 = 1'b1;
      end
    end
  end

  // adder pipeline: stage 0 takes the issue, later stages shift
  always_ff @(posedge clk) begin
    if (!rstN) pipeV[0] <= 1'b0;
    else       pipeV[0] <= st.issue;
    pipeS[0] <= issueSet;
    pipeD[0] <= opA + opB;
  end

  for (genvar k = 1; k < LAT; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) pipeV[k] <= 1'b0;
      else       pipeV[k] <= pipeV[k-1];
      pipeS[k] <= pipeS[k-1];
      pipeD[k] <= pipeD[k-1];
    end
  end

  // partial-sum pool
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufValid <= '0;
    end else begin
      for (int i = 0; i < NBUF; i++)
        if (st.freeMask[i]) bufValid[i] <= 1'b0;
      if (st.wrIn) begin
        bufValid[slot0] <= 1'b1;
        bufSet[slot0]   <= inSet;
        bufData[slot0]  <= inData;
      end
      if (st.wrAo) begin
        bufValid[st.wrIn ? slot1 : slot0] <= 1'b1;
        bufSet[st.wrIn ? slot1 : slot0]   <= aoSet;
        bufData[st.wrIn ? slot1 : slot0]  <= aoData;
      end
    end
  end

endmodule

// File: rtl/set_reduce_ctrl.sv
module set_reduce_ctrl
  import set_reduce_pkg::*;
#(
  parameter int SET_W = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [SET_W-1:0] inSet,
  input  logic             inLast,
  input  logic [NBUF-1:0]  bufValid,
  input  logic [SET_W-1:0] bufSet [NBUF],
  input  logic             aoValid,
  input  logic [SET_W-1:0] aoSet,
  output strobe_t          st,
  output logic             inReady,
  output logic             emit
);

  localparam int NSET = 1 << SET_W;

  logic [CNT_W-1:0] cnt [NSET];
  logic             lastSeen [NSET];

  logic             inFire, aoLive, anyFree;
  logic             hitAo, hitIn, hitPair, hitDone;
  logic [IDX_W-1:0] idxAo, idxIn, idxP, idxQ, idxDone;
  logic             merged;
  logic [SET_W-1:0] mergeSet;

  assign inReady = $countones(~bufValid) >= 2;
  assign inFire  = inValid && inReady;
  assign emit    = aoValid && lastSeen[aoSet] && (cnt[aoSet] == CNT_W'(1));
  assign aoLive  = aoValid && !emit;
  assign anyFree = |(~bufValid);

  // tag comparisons across the pool
  always_comb begin
    hitAo = 1'b0; hitIn = 1'b0; hitPair = 1'b0; hitDone = 1'b0;
    idxAo = '0; idxIn = '0; idxP = '0; idxQ = '0; idxDone = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (bufValid[i] && bufSet[i] == aoSet && !hitAo) begin
        hitAo = 1'b1; idxAo = IDX_W'(i);
      end
      if (bufValid[i] && bufSet[i] == inSet && !hitIn) begin
        hitIn = 1'b1; idxIn = IDX_W'(i);
      end
      if (bufValid[i] && lastSeen[bufSet[i]] && cnt[bufSet[i]] == CNT_W'(1) && !hitDone) begin
        hitDone = 1'b1; idxDone = IDX_W'(i);
      end
      for (int j = i + 1; j < NBUF; j++) begin
        if (bufValid[i] && bufValid[j] && bufSet[i] == bufSet[j] && !hitPair) begin
          hitPair = 1'b1; idxP = IDX_W'(i); idxQ = IDX_W'(j);
        end
      end
    end
  end

  // priority rules: one adder issue per cycle at most
  always_comb begin
    st = '0;
    merged = 1'b0;
    mergeSet = '0;
    if (aoLive && hitAo) begin
      st.issue = 1'b1; st.srcA = A_BUF; st.idxA = idxAo; st.srcB = B_AO;
      st.freeMask[idxAo] = 1'b1; st.wrIn = inFire;
      merged = 1'b1; mergeSet = aoSet;
    end else if (hitPair) begin
      st.issue = 1'b1; st.srcA = A_BUF; st.idxA = idxP; st.srcB = B_BUF; st.idxB = idxQ;
      st.freeMask[idxP] = 1'b1; st.freeMask[idxQ] = 1'b1;
      st.wrIn = inFire; st.wrAo = aoLive;
      merged = 1'b1; mergeSet = bufSet[idxP];
    end else if (inFire && aoLive && inSet == aoSet) begin
      st.issue = 1'b1; st.srcA = A_IN; st.srcB = B_AO;
      merged = 1'b1; mergeSet = inSet;
    end else if (inFire && hitIn) begin
      st.issue = 1'b1; st.srcA = A_IN; st.srcB = B_BUF; st.idxB = idxIn;
      st.freeMask[idxIn] = 1'b1; st.wrAo = aoLive;
      merged = 1'b1; mergeSet = inSet;
    end else if (inFire) begin
      st.issue = 1'b1; st.srcA = A_IN; st.srcB = B_ZERO; st.wrAo = aoLive;
    end else if (aoLive) begin
      if (anyFree) st.wrAo = 1'b1;
      else begin
        st.issue = 1'b1; st.srcA = A_AO; st.srcB = B_ZERO;
      end
    end else if (hitDone) begin
      st.issue = 1'b1; st.srcA = A_BUF; st.idxA = idxDone; st.srcB = B_ZERO;
      st.freeMask[idxDone] = 1'b1;
    end
  end

  // live-value count and final-input flag per set
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NSET; s++) begin
        cnt[s] <= '0;
        lastSeen[s] <= 1'b0;
      end
    end else begin
      for (int s = 0; s < NSET; s++) begin
        if (emit && aoSet == SET_W'(s)) begin
          cnt[s] <= '0;
          lastSeen[s] <= 1'b0;
        end else begin
          if ((inFire && inSet == SET_W'(s)) && !(merged && mergeSet == SET_W'(s)))
            cnt[s] <= cnt[s] + CNT_W'(1);
          else if (!(inFire && inSet == SET_W'(s)) && (merged && mergeSet == SET_W'(s)))
            cnt[s] <= cnt[s] - CNT_W'(1);
          if (inFire && inLast && inSet == SET_W'(s)) lastSeen[s] <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/set_reduce.sv
module set_reduce
  import set_reduce_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SET_W  = 3,
  parameter int LAT    = 14,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [SET_W-1:0]  inSet,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output logic              outValid,
  output logic [SET_W-1:0]  outSet,
  output logic [DATA_W-1:0] outSum
);

  strobe_t           st;
  logic [NBUF-1:0]   bufValid;
  logic [SET_W-1:0]  bufSet [NBUF];
  logic              aoValid;
  logic [SET_W-1:0]  aoSet;
  logic [DATA_W-1:0] aoData;
  logic              emit;

  set_reduce_ctrl #(.SET_W(SET_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSet(inSet), .inLast(inLast),
    .bufValid(bufValid), .bufSet(bufSet), .aoValid(aoValid), .aoSet(aoSet),
    .st(st), .inReady(inReady), .emit(emit)
  );

  set_reduce_dp #(.DATA_W(DATA_W), .SET_W(SET_W), .LAT(LAT)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .inSet(inSet), .inData(inData),
    .bufValid(bufValid), .bufSet(bufSet), .aoValid(aoValid), .aoSet(aoSet),
    .aoData(aoData)
  );

  assign outValid = emit;
  assign outSet   = aoSet;
  assign outSum   = aoData;

endmodule

// File: rtl/set_reduce_chk.sv
module set_reduce_chk
  import set_reduce_pkg::*;
#(
  parameter int SET_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic [SET_W-1:0] outSet,
  input strobe_t          st,
  input logic [NBUF-1:0]  bufValid
);

  // R1
  free_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.freeMask & ~bufValid) == '0);

  // R5
  slot_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrIn || st.wrAo) |-> (|(~bufValid | st.freeMask)));

  // R8
  slot_two_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrIn && st.wrAo) |-> ($countones(~bufValid | st.freeMask) >= 2));

  // R8
  src_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.issue && (st.srcA == A_IN || st.wrIn)) |-> (inValid && inReady));

  // R6
  emit_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !(outValid && outSet == $past(outSet)));

endmodule

bind set_reduce set_reduce_chk #(.SET_W(SET_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outSet(outSet), .st(st), .bufValid(bufValid)
);

// File: tb/set_reduce_test.sv
module set_reduce_test;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int SET_W  = 3;
  localparam int LAT    = 14;
  localparam int NSET   = 1 << SET_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [SET_W-1:0] inSet = '0;
  logic [DATA_W-1:0] inData = '0;
  logic inLast = 1'b0;
  logic inReady, outValid;
  logic [SET_W-1:0] outSet;
  logic [DATA_W-1:0] outSum;

  always #(CLK_PERIOD/2) clk = ~clk;

  set_reduce #(.DATA_W(DATA_W), .SET_W(SET_W), .LAT(LAT)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inSet(inSet), .inData(inData), .inLast(inLast),
    .outValid(outValid), .outSet(outSet), .outSum(outSum)
  );

  typedef struct {
    logic [SET_W-1:0]  set;
    logic [DATA_W-1:0] sum;
    string             tag;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] acc [NSET];
  bit pending [NSET];

  task automatic check(bit ok, string tag, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: match each emitted total against the scoreboard
  always @(negedge clk) begin
    int found;
    if (rstN && outValid) begin
      found = -1;
      for (int k = 0; k < expQ.size(); k++)
        if (found < 0 && expQ[k].set == outSet) found = k;
      if (found < 0) check(1'b0, "R6", "unexpected total for set", DATA_W'(outSet), '0);
      else begin
        check(outSum == expQ[found].sum, expQ[found].tag, "set total", outSum, expQ[found].sum);
        pending[outSet] = 1'b0;
        expQ.delete(found);
      end
    end
  end

  task automatic send(int set, logic [DATA_W-1:0] data, bit last, string tag);
    bit ok;
    item_t it;
    @(negedge clk);
    inValid = 1'b1; inSet = SET_W'(set); inData = data; inLast = last;
    ok = inReady;
    while (!ok) begin
      @(negedge clk);
      ok = inReady;
    end
    @(posedge clk);
    acc[set] = acc[set] + data;
    if (last) begin
      it.set = SET_W'(set); it.sum = acc[set]; it.tag = tag;
      expQ.push_back(it);
      pending[set] = 1'b1;
      acc[set] = '0;
    end
    #1 inValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitFree(int set);
    while (pending[set]) @(negedge clk);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (LAT + 2) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ids [3];
    int left [3];
    int k;
    for (int s = 0; s < NSET; s++) begin acc[s] = '0; pending[s] = 1'b0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R8", "outValid during reset", DATA_W'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R8", "inReady after reset", DATA_W'(inReady), 1);
    check(outValid == 1'b0, "R8", "outValid after reset", DATA_W'(outValid), 0);

    // R7 / R5: lone single-value set on an idle block
    send(5, 32'd77, 1'b1, "R5");
    repeat (LAT - 2) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R7", "output one cycle early", DATA_W'(outValid), 0);
    @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b1 && outSet == 3'd5, "R7", "output at adder depth", DATA_W'(outValid), 1);
    drain();

    // R3: one set streamed every cycle
    for (int i = 0; i < 20; i++) send(1, DATA_W'(i * 3 + 1), i == 19, "R3");
    drain();

    // R1 and R9: held value meets adder output while a single-value set arrives
    send(2, 32'd10, 1'b0, "R1");
    send(2, -32'sd4, 1'b1, "R1");
    idle(13);
    send(3, 32'd1000, 1'b1, "R9");
    drain();

    // R2 / R4: dense interleaving of two sets
    for (int i = 0; i < 12; i++) begin
      send(4, DATA_W'(i + 100), i == 11, "R4");
      send(6, DATA_W'(7 * i), i == 11, "R2");
    end
    drain();

    // R10: reuse a tag whose total was already emitted
    waitFree(5);
    send(5, 32'd5, 1'b0, "R10");
    send(5, 32'hFFFF_FFFF, 1'b1, "R10");
    drain();

    // R6: random interleavings of three open sets
    for (int r = 0; r < 25; r++) begin
      for (int j = 0; j < 3; j++) begin
        ids[j] = (r * 3 + j) % NSET;
        waitFree(ids[j]);
        left[j] = 1 + int'($urandom % 6);
      end
      while (left[0] + left[1] + left[2] > 0) begin
        k = int'($urandom % 3);
        if (left[k] > 0) begin
          left[k]--;
          send(ids[k], DATA_W'($urandom), left[k] == 0, "R6");
          if ($urandom % 4 == 0) idle(1);
        end
      end
    end
    drain();
    check(expQ.size() == 0, "R6", "totals still missing", DATA_W'(expQ.size()), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule